// File: doc/BRIEF.md
# Streaming Bitmap Set Intersection Tree

This block computes the intersection of eight sets that arrive at the same time as eight independent streams. A set is sent as a list of beats, one for each non-empty group, in strictly ascending group order. Each beat carries a group number and a bitmap word. Bit j of the bitmap stands for element `group * MAP_W + j`. A set is closed by a separate end-of-set beat.

The block is built as a balanced binary tree of two-input merge cells. Each cell walks its two streams in ascending group order. When the group numbers are equal, it forms the AND of the two bitmaps and passes on only non-zero results. When they differ, it throws away the beat with the smaller group number. When one stream has ended, the cell drains what is left of the other. After both streams have ended, it sends a single end-of-set beat.

Every cell registers its output and waits while the next level applies back-pressure. The root stream is therefore the intersection of all eight sets, in the same bitmap format. Sets follow one another back to back, so a new batch of eight sets can start as soon as the previous end markers have been accepted.

Top module: `bitset_isect_tree`

## Requirements
- R1: An input beat is `{in_eos[i], in_gid[i], in_map[i]}`. With in_eos low, bit j of the map means element `gid*32+j` is in the set. With in_eos high, the beat only ends the set, and its gid and map are ignored.
- R2: The output data beats of a batch are the groups present in all eight sets, in strictly ascending group order, with each group appearing at most once.
- R3: For a group present in every set, the output map is the bitwise AND of the eight maps, including group 1023 and all-ones maps.
- R4: A group whose ANDed map is all zeros produces no output beat.
- R5: When group numbers differ, the smaller one is discarded without output. Sets that share no group give an output with no data beats.
- R6: When some inputs end early, the data left on the other inputs is consumed and discarded. Exactly one end-of-set beat (out_eos high) closes each batch, after all eight end markers.
- R7: If any input set is empty (only its end beat), the batch output is a lone end-of-set beat.
- R8: While out_valid is high and out_ready is low, out_valid, out_gid, out_map and out_eos hold their values, and no beat is lost or duplicated under any pattern of input valid and output ready.
- R9: Several batches sent back to back on every input are intersected independently, in order.
- R10: During and right after synchronous reset (rst high), out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Beat present, one bit per input stream |
| in_ready | output | N_IN | Beat accepted this cycle, one bit per input |
| in_eos | input | N_IN | End-of-set marker, one bit per input |
| in_gid | input | N_IN*GID_W | Group numbers, stream i in bits [i*GID_W +: GID_W] |
| in_map | input | N_IN*MAP_W | Bitmaps, stream i in bits [i*MAP_W +: MAP_W] |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream accepts the result beat |
| out_eos | output | 1 | Result beat ends a batch |
| out_gid | output | GID_W | Result group number |
| out_map | output | MAP_W | Result bitmap (AND of all matches) |

## Verification
The same cycle can require two things of a merge cell. It must hand a held result to the next level and load a new match into the freed register. Or, while its output is stalled, it must discard a zero-AND pair or drain a leftover stream, both of which need no output slot. The bench provokes both situations by dropping input valid and output ready at random while running dense random batches, disjoint batches, zero-AND batches and uneven-length batches. Each accepted output beat is judged against a queue model of the intersection built from the same sets. A separate check requires that a stalled beat is still present and unchanged one cycle later.

// File: rtl/isect_pkg.sv
package isect_pkg;
  localparam int unsigned GID_W_DEF = 10;
  localparam int unsigned MAP_W_DEF = 32;
  localparam int unsigned N_IN_DEF  = 8;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/isect_oreg.sv
module isect_oreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         o_ready,
  output logic         o_valid,
  output logic [W-1:0] q,
  output logic         space
);
  assign space = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
    end else if (load) begin
      o_valid <= 1'b1;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  // R8: a stalled beat stays put
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(q)));

  // R10: reset clears the register
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> !o_valid);
endmodule

// File: rtl/isect_pe.sv
module isect_pe #(
  parameter int unsigned GID_W = 10,
  parameter int unsigned MAP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic             a_eos,
  input  logic [GID_W-1:0] a_gid,
  input  logic [MAP_W-1:0] a_map,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic             b_eos,
  input  logic [GID_W-1:0] b_gid,
  input  logic [MAP_W-1:0] b_map,
  output logic             o_valid,
  input  logic             o_ready,
  output logic             o_eos,
  output logic [GID_W-1:0] o_gid,
  output logic [MAP_W-1:0] o_map
);
  localparam int unsigned BW = 1 + GID_W + MAP_W;

  logic             space;
  logic             load;
  logic             d_eos;
  logic [MAP_W-1:0] anded;
  logic [BW-1:0]    d_beat;
  logic [BW-1:0]    q_beat;

  assign anded = a_map & b_map;

  // Merge decision: one step of a linear merge on ascending group numbers
  always_comb begin
    a_ready = 1'b0;
    b_ready = 1'b0;
    load    = 1'b0;
    d_eos   = 1'b0;
    if (a_valid && b_valid) begin
      if (a_eos && b_eos) begin
        if (space) begin
          a_ready = 1'b1;
          b_ready = 1'b1;
          load    = 1'b1;
          d_eos   = 1'b1;
        end
      end else if (a_eos) begin
        b_ready = 1'b1;              // drain leftover b
      end else if (b_eos) begin
        a_ready = 1'b1;              // drain leftover a
      end else if (a_gid == b_gid) begin
        if (anded == '0) begin
          a_ready = 1'b1;            // empty result needs no slot
          b_ready = 1'b1;
        end else if (space) begin
          a_ready = 1'b1;
          b_ready = 1'b1;
          load    = 1'b1;
        end
      end else if (a_gid < b_gid) begin
        a_ready = 1'b1;
      end else begin
        b_ready = 1'b1;
      end
    end
  end

  assign d_beat = d_eos ? {1'b1, {GID_W{1'b0}}, {MAP_W{1'b0}}}
                        : {1'b0, a_gid, anded};

  isect_oreg #(.W(BW)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .d       (d_beat),
    .o_ready (o_ready),
    .o_valid (o_valid),
    .q       (q_beat),
    .space   (space)
  );

  assign {o_eos, o_gid, o_map} = q_beat;

  // Checker state: last group sent in the current batch
  logic             prev_ok;
  logic [GID_W-1:0] prev_gid;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok <= 1'b0;
    end else if (o_valid && o_ready) begin
      prev_ok <= !o_eos;
    end
  end
  always_ff @(posedge clk) begin
    if (o_valid && o_ready) prev_gid <= o_gid;
  end

  // R2: data beats of a batch leave in strictly ascending order
  assert_ascending_R2: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_eos && prev_ok) |-> (o_gid > prev_gid));

  // R4: no all-zero data beat is ever offered
  assert_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_eos) |-> (o_map != '0));

  // R5: both data inputs advance together only on equal groups
  assert_match_only_R5: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready && !a_eos && b_valid && b_ready && !b_eos)
      |-> (a_gid == b_gid));

  // R6: end markers are consumed as a pair
  assert_eos_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready && a_eos) |-> (b_valid && b_ready && b_eos));
endmodule

// File: rtl/bitset_isect_tree.sv
module bitset_isect_tree
  import isect_pkg::*;
#(
  parameter int unsigned N_IN  = N_IN_DEF,
  parameter int unsigned GID_W = GID_W_DEF,
  parameter int unsigned MAP_W = MAP_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_IN-1:0]         in_ready,
  input  logic [N_IN-1:0]         in_eos,
  input  logic [N_IN*GID_W-1:0]   in_gid,
  input  logic [N_IN*MAP_W-1:0]   in_map,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_eos,
  output logic [GID_W-1:0]        out_gid,
  output logic [MAP_W-1:0]        out_map
);
  localparam int unsigned NODES = 2 * N_IN - 1;

  // Heap numbering: node k has children 2k and 2k+1; leaves are N_IN..NODES
  logic             nv [1:NODES];
  logic             nr [1:NODES];
  logic             ne [1:NODES];
  logic [GID_W-1:0] ng [1:NODES];
  logic [MAP_W-1:0] nm [1:NODES];

  initial begin
    assert (is_pow2(N_IN)) else $error("N_IN must be a power of two");
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_leaf
    assign nv[N_IN+i] = in_valid[i];
    assign ne[N_IN+i] = in_eos[i];
    assign ng[N_IN+i] = in_gid[i*GID_W +: GID_W];
    assign nm[N_IN+i] = in_map[i*MAP_W +: MAP_W];
    assign in_ready[i] = nr[N_IN+i];
  end

  for (genvar k = 1; k < N_IN; k++) begin : g_node
    isect_pe #(.GID_W(GID_W), .MAP_W(MAP_W)) u_pe (
      .clk     (clk),
      .rst     (rst),
      .a_valid (nv[2*k]),
      .a_ready (nr[2*k]),
      .a_eos   (ne[2*k]),
      .a_gid   (ng[2*k]),
      .a_map   (nm[2*k]),
      .b_valid (nv[2*k+1]),
      .b_ready (nr[2*k+1]),
      .b_eos   (ne[2*k+1]),
      .b_gid   (ng[2*k+1]),
      .b_map   (nm[2*k+1]),
      .o_valid (nv[k]),
      .o_ready (nr[k]),
      .o_eos   (ne[k]),
      .o_gid   (ng[k]),
      .o_map   (nm[k])
    );
  end

  assign out_valid = nv[1];
  assign out_eos   = ne[1];
  assign out_gid   = ng[1];
  assign out_map   = nm[1];
  assign nr[1]     = out_ready;
endmodule

// File: tb/tb_bitset_isect_tree.sv
module tb_bitset_isect_tree;
  localparam int N  = 8;
  localparam int GW = 10;
  localparam int MW = 32;
  localparam int BW = 1 + GW + MW;
  localparam int NG = 1 << GW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N-1:0]    in_eos = '0;
  logic [N*GW-1:0] in_gid = '0;
  logic [N*MW-1:0] in_map = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic            out_eos;
  logic [GW-1:0]   out_gid;
  logic [MW-1:0]   out_map;

  bitset_isect_tree #(.N_IN(N), .GID_W(GW), .MAP_W(MW)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_eos(in_eos),
    .in_gid(in_gid), .in_map(in_map),
    .out_valid(out_valid), .out_ready(out_ready), .out_eos(out_eos),
    .out_gid(out_gid), .out_map(out_map)
  );

  logic [BW-1:0] src [N][$];
  logic [BW-1:0] expq [$];
  logic [MW-1:0] mp [N][NG];
  bit            pr [N][NG];
  bit            held [N];
  int total = 0;
  int bad = 0;
  int cycles = 0;
  int valid_pct = 100;
  int ready_pct = 100;
  string cur_tag = "R2";
  bit            stall_seen = 0;
  logic [BW-1:0] stall_beat;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_sets();
    for (int i = 0; i < N; i++)
      for (int g = 0; g < NG; g++) begin
        pr[i][g] = 1'b0;
        mp[i][g] = '0;
      end
  endtask

  task automatic put(input int i, input int g, input logic [MW-1:0] m);
    pr[i][g] = 1'b1;
    mp[i][g] = m;
  endtask

  // Queue one batch on every input and the expected intersection
  task automatic add_batch();
    for (int g = 0; g < NG; g++) begin
      bit all_in = 1'b1;
      logic [MW-1:0] acc = '1;
      for (int i = 0; i < N; i++) begin
        if (pr[i][g]) begin
          src[i].push_back({1'b0, g[GW-1:0], mp[i][g]});
          acc = acc & mp[i][g];
        end else begin
          all_in = 1'b0;
        end
      end
      if (all_in && acc != '0) expq.push_back({1'b0, g[GW-1:0], acc});
    end
    for (int i = 0; i < N; i++) src[i].push_back({1'b1, {GW{1'b0}}, {MW{1'b0}}});
    expq.push_back({1'b1, {GW{1'b0}}, {MW{1'b0}}});
    clear_sets();
  endtask

  task automatic step();
    bit fire [N];
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (!held[i]) begin
        if (src[i].size() > 0 && $urandom_range(99) < valid_pct) begin
          in_valid[i] = 1'b1;
          {in_eos[i], in_gid[i*GW +: GW], in_map[i*MW +: MW]} = src[i][0];
          held[i] = 1'b1;
        end else begin
          in_valid[i] = 1'b0;
          in_eos[i] = $urandom_range(1);
          in_gid[i*GW +: GW] = GW'($urandom());
          in_map[i*MW +: MW] = $urandom();
        end
      end
    end
    out_ready = ($urandom_range(99) < ready_pct);
    #4;
    for (int i = 0; i < N; i++) fire[i] = in_valid[i] && in_ready[i];
    if (stall_seen)
      check(out_valid && ({out_eos, out_gid, out_map} == stall_beat), "R8",
            "stalled beat changed", {out_eos, out_gid, out_map}, stall_beat);
    stall_seen = out_valid && !out_ready;
    stall_beat = {out_eos, out_gid, out_map};
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, cur_tag, "unexpected beat", {out_eos, out_gid, out_map}, '0);
      end else begin
        logic [BW-1:0] e = expq.pop_front();
        if (e[BW-1])
          check(out_eos == 1'b1, cur_tag, "end marker expected",
                {out_eos, out_gid, out_map}, e);
        else
          check({out_eos, out_gid, out_map} == e, cur_tag, "data beat",
                {out_eos, out_gid, out_map}, e);
      end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++)
      if (fire[i]) begin
        void'(src[i].pop_front());
        held[i] = 1'b0;
        in_valid[i] = 1'b0;
      end
  endtask

  task automatic run(input string tag);
    int n = 0;
    bit busy = 1'b1;
    cur_tag = tag;
    while (busy && n < 20000) begin
      step();
      n++;
      busy = (expq.size() != 0);
      for (int i = 0; i < N; i++) if (src[i].size() != 0) busy = 1'b1;
    end
    for (int k = 0; k < 6; k++) step();  // catch extra beats
    check(expq.size() == 0, tag, "expected beats left", BW'(expq.size()), '0);
  endtask

  initial begin
    int wd_limit = 150000;
    wait (cycles > wd_limit);
    check(1'b0, "R2", "watchdog expired", BW'(cycles), BW'(wd_limit));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) held[i] = 1'b0;
    clear_sets();
    repeat (3) @(posedge clk);
    #6;
    check(out_valid == 1'b0, "R10", "out_valid in reset", BW'(out_valid), '0);
    @(negedge clk);
    rst = 1'b0;
    #4;
    check(out_valid == 1'b0, "R10", "out_valid after reset", BW'(out_valid), '0);

    // R1: one element (group 5, bit 7) common to all sets
    for (int i = 0; i < N; i++) put(i, 5, 32'h0000_0080);
    put(0, 3, 32'hFFFF_FFFF);
    add_batch();
    run("R1");

    // R2/R3: dense random sets sharing a core
    for (int g = 0; g < 200; g++) begin
      if ($urandom_range(3) == 0) begin
        logic [MW-1:0] core = $urandom() | 32'h1;
        for (int i = 0; i < N; i++) put(i, g, core | $urandom());
      end else begin
        for (int i = 0; i < N; i++)
          if ($urandom_range(2) != 0) put(i, g, $urandom());
      end
    end
    add_batch();
    run("R2/R3");

    // R5: disjoint sets
    for (int g = 0; g < 64; g++) begin
      put(g % 2, g, 32'hFFFF_FFFF);
      for (int i = 2; i < N; i++) put(i, g, 32'hFFFF_FFFF);
    end
    add_batch();
    run("R5");

    // R4: matched groups whose AND is zero
    for (int g = 0; g < 21; g++)
      for (int i = 0; i < N; i++) begin
        if (g % 2 == 0 && i == 0) put(i, g, 32'h0000_FFFF);
        else if (g % 2 == 0 && i == 7) put(i, g, 32'hFFFF_0000);
        else put(i, g, 32'hF0F0_F0F0 | g);
      end
    add_batch();
    run("R4");

    // R7: one empty set
    for (int g = 0; g < 50; g++)
      for (int i = 0; i < N; i++)
        if (i != 3) put(i, g, 32'hFFFF_FFFF);
    add_batch();
    run("R7");

    // R6: uneven set lengths force draining
    for (int g = 0; g < 600; g++)
      for (int i = 0; i < N; i++)
        if (i != 2 || g < 4) put(i, g, (g == 2 && i == 5) ? 32'h0 + 32'h4 : 32'hFFFF_FFFF);
    add_batch();
    run("R6");

    // R3: top group number and all-ones maps
    for (int i = 0; i < N; i++) begin
      put(i, NG - 2, 32'hFFFF_FFFF);
      put(i, NG - 1, (i == 1) ? 32'h8000_0001 : 32'hFFFF_FFFF);
    end
    add_batch();
    run("R3");

    // R8/R9: back-to-back batches under random valid and ready
    valid_pct = 60;
    ready_pct = 30;
    for (int b = 0; b < 3; b++) begin
      for (int g = 0; g < 120; g++) begin
        if ($urandom_range(2) == 0) begin
          logic [MW-1:0] core = $urandom() | 32'h100;
          for (int i = 0; i < N; i++) put(i, g, core | $urandom());
        end else if ($urandom_range(1) == 0) begin
          for (int i = 0; i < N; i++)
            if ($urandom_range(3) != 0) put(i, g, $urandom());
        end
      end
      add_batch();
    end
    run("R8/R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule